// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block is a stereo serial audio transceiver with three receive lanes and three transmit lanes. All six lanes share one bit clock and one frame clock, and both clocks come from outside the block. A static configuration input chooses the frame alignment: I2S, left-justified or right-justified. A second static input chooses a frame length of 32 or 64 bit-clock cycles. Each half of a frame carries one channel, and the left channel is always sent first.

The bit clock and the frame clock are oversampled by the block's own fast clock. On the receive side, each lane turns its serial stream into a pair of 24-bit two's-complement words, one left and one right. The block then pulses a single frame-valid strobe when the words are ready. On the transmit side, a pair of parallel 24-bit words per lane is sampled at the start of each frame and shifted out in the same alignment. With 32-cycle frames only the upper 16 bits of each sample fit on the line, and received words have their lower bits cleared.

Top module: `audio_serial_port`

## Requirements
- R1: With `fmt` = 0 (I2S), the left channel is the half-frame in which `lrck` is low, and the MSB of a channel sits in the second bit slot after the `lrck` transition that opens its half.
- R2: With `fmt` = 1 (left-justified), the left channel is the half-frame in which `lrck` is high, and the MSB sits in the first bit slot after the transition. Code `fmt` = 3 behaves as code 1.
- R3: With `fmt` = 2 (right-justified), the left channel is the half-frame in which `lrck` is high, and the LSB of the carried bits sits in the last slot of the half. In 64-cycle frames this puts the MSB in slot 8 of the half; in 32-cycle frames it puts the MSB in slot 0.
- R4: With `frame64` = 0, each half-frame has 16 slots and carries sample bits 23..8. Received words have bits 7..0 equal to zero. With `frame64` = 1, all 24 bits are carried.
- R5: Every transmit slot that carries no sample bit drives a 0. Outputs are also 0 after reset and until the first `lrck` transition.
- R6: `rx_valid` is a one-cycle pulse that follows the first rising bit-clock edge of a left half-frame, but only if a complete left half and right half were received before it. `rx_left` and `rx_right` change only together with that pulse.
- R7: The transmit words for a frame are sampled once, at the falling bit-clock edge where `lrck` moves to the left-channel level. Changes to `tx_left`/`tx_right` at any other time do not alter the frame in progress.
- R8: The three receive lanes and the three transmit lanes each carry their own data. Lane n occupies bits [24n+23:24n] of each packed word bus.
- R9: Receive data and `lrck` are sampled at rising `bclk` edges. Transmit data changes only after falling `bclk` edges, and it stays stable across the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Alignment: 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| frame64 | input | 1 | 1 selects 64-cycle frames, 0 selects 32-cycle frames |
| bclk | input | 1 | External bit clock |
| lrck | input | 1 | External frame clock |
| sdin | input | 3 | Serial receive lanes |
| sdout | output | 3 | Serial transmit lanes |
| tx_left | input | 72 | Left transmit words, 24 bits per lane |
| tx_right | input | 72 | Right transmit words, 24 bits per lane |
| rx_left | output | 72 | Left received words, 24 bits per lane |
| rx_right | output | 72 | Right received words, 24 bits per lane |
| rx_valid | output | 1 | One-cycle frame-valid strobe |

## Verification
The assertions check the following on every cycle:
- the single-cycle shape of the frame strobe;
- that received words hold between strobes;
- that a strobe only follows a left-half start;
- that the low bits are cleared in short frames;
- that the transmit hold registers change only at a frame start;
- that a slot with no assigned bit drives a 0.

Some behaviour only the bench scenarios can show. These are whether each bit lands in the right slot for each alignment and frame length, and whether the channel polarity of the frame clock is handled. They also cover the extra wrap slot of I2S in short frames and lane independence. For these, the bench compares reassembled words and reassembled transmit streams against streams it builds arithmetically for all eight configurations.

// File: rtl/asp_pkg.sv
package asp_pkg;

  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;

  typedef struct packed {
    logic       hit;      // slot carries a sample bit
    logic       prev_ch;  // bit belongs to the channel before the current half
    logic [7:0] pos;      // distance of the bit from the MSB
  } slot_map_t;

  // slots per channel for the chosen frame length
  function automatic int half_len(input logic frame64);
    return frame64 ? 32 : 16;
  endfunction

  // sample bits that fit into one half-frame
  function automatic int carried_bits(input logic frame64, input int sw);
    int h;
    h = half_len(frame64);
    return (h < sw) ? h : sw;
  endfunction

  // where a given slot of a half-frame lands inside a sample
  function automatic slot_map_t map_slot(input logic [1:0] fmt, input int half,
                                         input int nbits, input int slot);
    slot_map_t m;
    int p;
    m = '0;
    if (fmt == FMT_I2S) begin
      if (slot == 0) begin
        p         = half - 1;
        m.prev_ch = 1'b1;
      end else begin
        p = slot - 1;
      end
    end else if (fmt == FMT_RJ) begin
      p = slot - (half - nbits);
    end else begin
      p = slot;
    end
    m.hit = (p >= 0) && (p < nbits);
    m.pos = m.hit ? 8'(p) : 8'd0;
    return m;
  endfunction

endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             lrck,
  input  logic [LANES-1:0] sdin,
  output logic             lrck_s,
  output logic [LANES-1:0] sdin_s,
  output logic             rise_evt,
  output logic             fall_evt
);
  localparam int W = LANES + 2;

  logic [W-1:0] st1, st2;
  logic         bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1    <= '0;
      st2    <= '0;
      bclk_q <= 1'b0;
    end else begin
      st1    <= {bclk, lrck, sdin};
      st2    <= st1;
      bclk_q <= st2[W-1];
    end
  end

  assign lrck_s   = st2[W-2];
  assign sdin_s   = st2[LANES-1:0];
  assign rise_evt = st2[W-1] & ~bclk_q;
  assign fall_evt = ~st2[W-1] & bclk_q;

endmodule

// File: rtl/asp_slot_track.sv
module asp_slot_track
  import asp_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int SW     = 24,
  parameter int IDX_W  = $clog2(SW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             lrck,
  input  logic [1:0]       fmt,
  input  logic             frame64,
  output logic             half_edge,
  output logic             start_left,
  output logic             hit,
  output logic             bit_left,
  output logic [IDX_W-1:0] bit_idx
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic              seen_q, lr_q, locked_q;
  logic [SLOT_W-1:0] slot_q, slot_now;
  logic              locked_now;
  slot_map_t         m;

  assign half_edge  = seen_q && (lrck != lr_q);
  assign slot_now   = half_edge ? '0 : ((slot_q == SLOT_MAX) ? SLOT_MAX : slot_q + 1'b1);
  assign locked_now = locked_q | half_edge;
  assign start_left = (fmt == FMT_I2S) ? ~lrck : lrck;

  always_comb m = map_slot(fmt, half_len(frame64), carried_bits(frame64, SW), int'(slot_now));

  assign hit      = locked_now & m.hit;
  assign bit_left = m.prev_ch ? ~start_left : start_left;
  assign bit_idx  = IDX_W'(SW - 1 - int'(m.pos));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      lr_q     <= 1'b0;
      locked_q <= 1'b0;
      slot_q   <= '0;
    end else if (evt) begin
      seen_q   <= 1'b1;
      lr_q     <= lrck;
      locked_q <= locked_now;
      slot_q   <= slot_now;
    end
  end

endmodule

// File: rtl/asp_rx_lane.sv
module asp_rx_lane #(
  parameter int SW    = 24,
  parameter int IDX_W = $clog2(SW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             din,
  input  logic             half_edge,
  input  logic             start_left,
  input  logic             hit,
  input  logic             bit_left,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             commit,
  output logic [SW-1:0]    word_l,
  output logic [SW-1:0]    word_r
);
  logic [SW-1:0] shl, shr, l_n, r_n;

  always_comb begin
    l_n = shl;
    r_n = shr;
    if (half_edge) begin
      if (start_left) l_n = '0;
      else            r_n = '0;
    end
    if (hit) begin
      if (bit_left) l_n[bit_idx] = din;
      else          r_n[bit_idx] = din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shl    <= '0;
      shr    <= '0;
      word_l <= '0;
      word_r <= '0;
    end else if (evt) begin
      shl <= l_n;
      shr <= r_n;
      if (commit) begin
        word_l <= shl;
        word_r <= r_n;
      end
    end
  end

endmodule

// File: rtl/asp_tx_lane.sv
module asp_tx_lane #(
  parameter int SW    = 24,
  parameter int IDX_W = $clog2(SW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             frame_start,
  input  logic             hit,
  input  logic             bit_left,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic [SW-1:0]    word_l_in,
  input  logic [SW-1:0]    word_r_in,
  output logic             sdout
);
  logic [SW-1:0] hold_l, hold_r, src_l;

  assign src_l = frame_start ? word_l_in : hold_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      sdout  <= 1'b0;
    end else if (evt) begin
      if (frame_start) begin
        hold_l <= word_l_in;
        hold_r <= word_r_in;
      end
      sdout <= hit ? (bit_left ? src_l[bit_idx] : hold_r[bit_idx]) : 1'b0;
    end
  end

  // R7
  tx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt && frame_start) |=> ($stable(hold_l) && $stable(hold_r)));

  // R5
  tx_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !hit) |=> !sdout);

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int SW     = 24,
  parameter int SLOT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt,
  input  logic                frame64,
  input  logic                bclk,
  input  logic                lrck,
  input  logic [LANES-1:0]    sdin,
  output logic [LANES-1:0]    sdout,
  input  logic [LANES*SW-1:0] tx_left,
  input  logic [LANES*SW-1:0] tx_right,
  output logic [LANES*SW-1:0] rx_left,
  output logic [LANES*SW-1:0] rx_right,
  output logic                rx_valid
);
  localparam int IDX_W = $clog2(SW);
  localparam int LOWB  = SW - 16;

  logic             lrck_s, rise_evt, fall_evt;
  logic [LANES-1:0] sdin_s;

  logic             rx_edge, rx_start_left, rx_hit, rx_bit_left;
  logic [IDX_W-1:0] rx_idx;
  logic             tx_edge, tx_start_left, tx_hit, tx_bit_left;
  logic [IDX_W-1:0] tx_idx;

  logic got_left, got_right;
  logic rx_left_start, rx_commit, tx_frame_start;

  asp_sync #(.LANES(LANES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrck(lrck), .sdin(sdin),
    .lrck_s(lrck_s), .sdin_s(sdin_s), .rise_evt(rise_evt), .fall_evt(fall_evt));

  asp_slot_track #(.SLOT_W(SLOT_W), .SW(SW), .IDX_W(IDX_W)) u_rx_slot (
    .clk(clk), .rst_n(rst_n), .evt(rise_evt), .lrck(lrck_s), .fmt(fmt), .frame64(frame64),
    .half_edge(rx_edge), .start_left(rx_start_left), .hit(rx_hit),
    .bit_left(rx_bit_left), .bit_idx(rx_idx));

  asp_slot_track #(.SLOT_W(SLOT_W), .SW(SW), .IDX_W(IDX_W)) u_tx_slot (
    .clk(clk), .rst_n(rst_n), .evt(fall_evt), .lrck(lrck_s), .fmt(fmt), .frame64(frame64),
    .half_edge(tx_edge), .start_left(tx_start_left), .hit(tx_hit),
    .bit_left(tx_bit_left), .bit_idx(tx_idx));

  assign rx_left_start  = rise_evt && rx_edge && rx_start_left;
  assign rx_commit      = rx_left_start && got_right;
  assign tx_frame_start = fall_evt && tx_edge && tx_start_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got_left  <= 1'b0;
      got_right <= 1'b0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= rx_commit;
      if (rise_evt && rx_edge) begin
        if (rx_start_left) begin
          got_left  <= 1'b1;
          got_right <= 1'b0;
        end else if (got_left) begin
          got_right <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    asp_rx_lane #(.SW(SW), .IDX_W(IDX_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .evt(rise_evt), .din(sdin_s[g]),
      .half_edge(rx_edge), .start_left(rx_start_left), .hit(rx_hit),
      .bit_left(rx_bit_left), .bit_idx(rx_idx), .commit(rx_commit),
      .word_l(rx_left[g*SW +: SW]), .word_r(rx_right[g*SW +: SW]));

    asp_tx_lane #(.SW(SW), .IDX_W(IDX_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .evt(fall_evt), .frame_start(tx_frame_start),
      .hit(tx_hit), .bit_left(tx_bit_left), .bit_idx(tx_idx),
      .word_l_in(tx_left[g*SW +: SW]), .word_r_in(tx_right[g*SW +: SW]),
      .sdout(sdout[g]));

    if (LOWB > 0) begin : g_fill
      // R4
      short_frame_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !frame64) |-> ((rx_left[g*SW +: LOWB] == '0) && (rx_right[g*SW +: LOWB] == '0)));
    end
  end

  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

  // R6
  rx_after_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_left_start));

endmodule

// File: tb/tb_audio_serial_port.sv
module tb_audio_serial_port;
  localparam int LANES = 3;
  localparam int SW    = 24;
  localparam int NF    = 4;
  localparam int MAXP  = (NF + 1) * 64;
  localparam int HB    = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst_n = 1'b0;
  logic [1:0]          fmt = 2'd0;
  logic                frame64 = 1'b0;
  logic                bclk = 1'b1;
  logic                lrck = 1'b0;
  logic [LANES-1:0]    sdin = '0;
  logic [LANES-1:0]    sdout;
  logic [LANES*SW-1:0] tx_left = '0, tx_right = '0;
  logic [LANES*SW-1:0] rx_left, rx_right;
  logic                rx_valid;

  audio_serial_port #(.LANES(LANES), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .frame64(frame64), .bclk(bclk), .lrck(lrck),
    .sdin(sdin), .sdout(sdout), .tx_left(tx_left), .tx_right(tx_right),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

  int n_checks = 0, n_fail = 0;
  int cfg = 0, rx_cnt = 0;
  bit running = 0, hold_bad = 0;
  logic [LANES-1:0] istr [MAXP];
  logic [LANES-1:0] texp [MAXP];
  logic [LANES-1:0] tgot [MAXP];
  logic [LANES*SW-1:0] prev_l, prev_r;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cfg=%0d act=%h exp=%h", req, cfg, act, exp);
    end
  endtask

  function automatic logic [23:0] tb_word(input int c, input int f, input int l, input int ch);
    logic [23:0] w;
    if (f == 0)      w = (ch != 0) ? 24'h7FFFFF : 24'h800000;
    else if (f == 1) w = (ch != 0) ? 24'h000001 : 24'hFFFFFF;
    else             w = 24'((f * 131 + ch * 5 + c * 29 + 3) * 193847);
    return w ^ 24'(l * 32'h1F2E3D);
  endfunction

  function automatic logic [23:0] trunc(input logic [23:0] w);
    return frame64 ? w : {w[23:8], 8'h00};
  endfunction

  function automatic string fmt_tag();
    case (fmt)
      2'd0:    return "R1";
      2'd2:    return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic place_bits(input int f, input int ch, input int l, input logic [23:0] w, input bit is_tx);
    int half, nb, off;
    half = frame64 ? 32 : 16;
    nb   = frame64 ? 24 : 16;
    off  = (fmt == 2'd0) ? 1 : ((fmt == 2'd2) ? half - nb : 0);
    for (int k = 0; k < nb; k++) begin
      if (is_tx) texp[f*2*half + ch*half + off + k][l] = w[23-k];
      else       istr[f*2*half + ch*half + off + k][l] = w[23-k];
    end
  endtask

  task automatic set_tx(input int f);
    for (int l = 0; l < LANES; l++) begin
      tx_left[l*SW +: SW]  = (f < NF) ? (tb_word(cfg, f, l, 0) ^ 24'hA5C3E1) : 24'h0;
      tx_right[l*SW +: SW] = (f < NF) ? (tb_word(cfg, f, l, 1) ^ 24'h3C5A96) : 24'h0;
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // receive monitor: R1 R2 R3 R4 R6 R8
  always @(negedge clk) begin
    if (running && rst_n) begin
      if (rx_valid) begin
        for (int l = 0; l < LANES; l++) begin
          check(rx_left[l*SW +: SW] == trunc(tb_word(cfg, rx_cnt, l, 0)),
                $sformatf("%s/R6/R8 rx left lane%0d frame%0d", fmt_tag(), l, rx_cnt),
                64'(rx_left[l*SW +: SW]), 64'(trunc(tb_word(cfg, rx_cnt, l, 0))));
          check(rx_right[l*SW +: SW] == trunc(tb_word(cfg, rx_cnt, l, 1)),
                $sformatf("%s/R6/R8 rx right lane%0d frame%0d", fmt_tag(), l, rx_cnt),
                64'(rx_right[l*SW +: SW]), 64'(trunc(tb_word(cfg, rx_cnt, l, 1))));
          if (!frame64)
            check((rx_left[l*SW +: 8] == 8'h0) && (rx_right[l*SW +: 8] == 8'h0), "R4 zero fill",
                  64'({rx_left[l*SW +: 8], rx_right[l*SW +: 8]}), 64'h0);
        end
        rx_cnt++;
      end else if ((rx_left != prev_l) || (rx_right != prev_r)) begin
        hold_bad = 1'b1;
      end
    end
    prev_l = rx_left;
    prev_r = rx_right;
  end

  task automatic run_cfg(input int c);
    int half, frm;
    logic leftlvl;
    logic [63:0] e, g;
    cfg     = c;
    fmt     = 2'(c / 2);
    frame64 = 1'(c % 2);
    half    = frame64 ? 32 : 16;
    frm     = 2 * half;
    leftlvl = (fmt == 2'd0) ? 1'b0 : 1'b1;
    rst_n   = 1'b0;
    bclk    = 1'b1;
    sdin    = '0;
    lrck    = ~leftlvl;
    for (int p = 0; p < MAXP; p++) begin
      istr[p] = '0; texp[p] = '0; tgot[p] = '0;
    end
    for (int f = 0; f < NF; f++)
      for (int l = 0; l < LANES; l++)
        for (int ch = 0; ch < 2; ch++) begin
          place_bits(f, ch, l, tb_word(c, f, l, ch), 1'b0);
          place_bits(f, ch, l, tb_word(c, f, l, ch) ^ ((ch != 0) ? 24'h3C5A96 : 24'hA5C3E1), 1'b1);
        end
    set_tx(0);
    rx_cnt   = 0;
    hold_bad = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    if (c == 0) begin
      check(!rx_valid, "R6 reset strobe", 64'(rx_valid), 64'h0);
      check(sdout == '0, "R5 reset output", 64'(sdout), 64'h0);
      check((rx_left == '0) && (rx_right == '0), "R6 reset words", rx_left[63:0], 64'h0);
    end
    running = 1'b1;
    for (int i = 0; i < 4; i++) begin
      bclk = 1'b0;
      wait_n(HB);
      check(sdout == '0, "R5 idle before lock", 64'(sdout), 64'h0);
      bclk = 1'b1;
      wait_n(HB);
    end
    for (int p = 0; p < (NF + 1) * frm; p++) begin
      bclk = 1'b0;
      lrck = ((p % frm) < half) ? leftlvl : ~leftlvl;
      sdin = istr[p];
      if ((p % frm) == half + 1) set_tx(p / frm + 1);
      wait_n(HB);
      tgot[p] = sdout;
      bclk = 1'b1;
      wait_n(HB);
    end
    running = 1'b0;
    check(rx_cnt == NF, "R6 frame count", 64'(rx_cnt), 64'(NF));
    check(!hold_bad, "R6 words held between strobes", 64'(hold_bad), 64'h0);
    for (int f = 0; f <= NF; f++)
      for (int l = 0; l < LANES; l++) begin
        e = '0; g = '0;
        for (int ph = 0; ph < frm; ph++) begin
          e[ph] = texp[f*frm + ph][l];
          g[ph] = tgot[f*frm + ph][l];
        end
        check(g == e, $sformatf("%s/%s/R5/R7/R8/R9 tx lane%0d frame%0d", fmt_tag(),
              frame64 ? "64" : "R4", l, f), g, e);
      end
  endtask

  bit done = 0;

  initial begin
    for (int c = 0; c < 8; c++) run_cfg(c);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule